// File: doc/BRIEF.md
# Configurable Crosspoint Pin Cell

This block is one routing cell of a pin-level crosspoint switch. A four-way data selector, steered by a two-bit select, picks one of four candidate legs. Each leg is taken either from its own routing-pool group input or from a neighbouring cell's selector output. The selector result is made available to neighbours as it is formed. It also passes through an output stage that is combinational, a transparent latch or an edge register, and then drives the pad. The pad input goes through an input stage with the same three choices before it returns to the routing pool.

The pad side produces only a logical data value and a logical drive enable. The enable follows an external enable signal whose active level is configurable. The cell can also force a constant level, as a jumper replacement does, and can run in open-drain fashion. Storage elements are timed by a strobe and a strobe enable, each chosen from two global pins or from pad-derived signals. Everything is set by one configuration word that is written through an addressed parallel port. Until that word has been written, the pad is never driven.

Top module: `xpt_io_cell`

## Requirements
- R1: With every leg on its group input, select value k (0..3) routes grp_in[k] to mux_out and, in combinational output mode, to pad_do in the same cycle.
- R2: Config bit k of leg_src (bits [3:0]) set to 1 feeds leg k from nbr_in[k], and grp_in[k] then has no effect on the output for select k.
- R3: Mode code 0 (in_mode bits [5:4], out_mode bits [7:6]) makes a stage combinational: grp_out follows pad_in without delay.
- R4: Mode code 2 makes a stage a register. It loads only on a cycle in which the selected strobe has risen and the selected strobe enable is high, and it holds at all other times.
- R5: Mode code 1 makes a stage a latch. It is transparent while the selected strobe is high and holds the last value seen while the strobe was high.
- R6: Bit 8 (oe_pol) at 1 drives the pad when oe_in is 1; at 0 it drives the pad when oe_in is 0.
- R7: Bit 9 (force enable) at 1 makes pad_do equal bit 10 (force value), whatever the selector result.
- R8: Bit 11 (open drain) at 1 drives the pad only when the data is 0, with pad_do at 0. Data 1 leaves pad_oe at 0.
- R9: pad_oe and pad_do stay 0 from reset until a configuration word has been written.
- R10: A write changes the configuration only when cfg_addr equals the cell's address. Writes to other addresses are ignored.
- R11: Bits [13:12] pick the strobe (0: gstb[0], 1: gstb[1], 2 or 3: io_stb). Bits [15:14] pick the strobe enable (0: gce[0], 1: gce[1], 2: io_ce, 3: always on). Strobes that are not selected have no effect.
- R12: An active-low reset clears the configuration and both storage elements asynchronously. Release is synchronised to clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration write address |
| cfg_wdata | input | 16 | Configuration word |
| grp_in | input | 4 | Routing-pool group inputs, one per leg |
| nbr_in | input | 4 | Neighbour selector outputs, one per leg |
| sel | input | 2 | Dynamic leg select |
| pad_in | input | 1 | Value seen at the pad |
| oe_in | input | 1 | Raw drive-enable request |
| gstb | input | 2 | Global strobe pins |
| gce | input | 2 | Global strobe-enable pins |
| io_stb | input | 1 | Pad-derived strobe |
| io_ce | input | 1 | Pad-derived strobe enable |
| grp_out | output | 1 | Staged pad input toward the routing pool |
| mux_out | output | 1 | Selector result toward neighbours |
| pad_do | output | 1 | Logical pad data |
| pad_oe | output | 1 | Logical pad drive enable |

## Verification
The strobe edge and the strobe enable can land in the same cycle as a change of the data being captured. The bench sets the strobe high, the enable low and new selector data all in one cycle, and then expects the old register value to remain. It then raises enable and strobe together and expects the new value one edge later. A second overlap is force and open drain used together: the forced value passes through the open-drain gating, and the expected pad_oe is worked out from the forced level rather than from the selector.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam int NLEG  = 4;
  localparam int SEL_W = $clog2(NLEG);

  typedef enum logic [1:0] {
    PM_COMB  = 2'd0,
    PM_LATCH = 2'd1,
    PM_REG   = 2'd2,
    PM_RSVD  = 2'd3
  } path_mode_e;

  typedef struct packed {
    logic [1:0]      ce_sel;
    logic [1:0]      clk_sel;
    logic            odrain;
    logic            force_val;
    logic            force_en;
    logic            oe_pol;
    path_mode_e      out_mode;
    path_mode_e      in_mode;
    logic [NLEG-1:0] leg_src;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/xpt_cfg_reg.sv
module xpt_cfg_reg
  import xpt_pkg::*;
#(
  parameter int          AW      = 4,
  parameter logic [AW-1:0] CELL_ID = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [CFG_W-1:0] wdata,
  output cell_cfg_t        cfg,
  output logic             cfg_valid
);

  cell_cfg_t cfg_q, cfg_d;
  logic      valid_q, valid_d;
  logic      hit;

  assign hit = we && (addr == CELL_ID);

  always_comb begin
    cfg_d   = cfg_q;
    valid_d = valid_q;
    if (hit) begin
      cfg_d   = cell_cfg_t'(wdata);
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end

  assign cfg       = cfg_q;
  assign cfg_valid = valid_q;

  // R10: a write aimed elsewhere leaves the word untouched
  p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cfg_q));

  // R10: a matching write lands in the next cycle
  p_own_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cfg_q == $past(wdata)) && valid_q);

endmodule

// File: rtl/xpt_clk_sel.sv
module xpt_clk_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_sel,
  input  logic [1:0] ce_sel,
  input  logic [1:0] gstb,
  input  logic [1:0] gce,
  input  logic       io_stb,
  input  logic       io_ce,
  output logic       stb_lvl,
  output logic       stb_rise,
  output logic       ce_lvl
);

  logic stb_d_q;

  always_comb begin
    unique case (clk_sel)
      2'd0:    stb_lvl = gstb[0];
      2'd1:    stb_lvl = gstb[1];
      default: stb_lvl = io_stb;
    endcase
  end

  always_comb begin
    unique case (ce_sel)
      2'd0:    ce_lvl = gce[0];
      2'd1:    ce_lvl = gce[1];
      2'd2:    ce_lvl = io_ce;
      default: ce_lvl = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_d_q <= 1'b0;
    else        stb_d_q <= stb_lvl;
  end

  assign stb_rise = stb_lvl && !stb_d_q;

  // R11: a detected rise is never reported on two cycles in a row
  p_single_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> !stb_rise);

endmodule

// File: rtl/xpt_leg_mux.sv
module xpt_leg_mux
  import xpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLEG-1:0]  leg_src,
  input  logic [NLEG-1:0]  grp_in,
  input  logic [NLEG-1:0]  nbr_in,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);

  logic [NLEG-1:0] leg;

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    assign leg[i] = leg_src[i] ? nbr_in[i] : grp_in[i];
  end

  assign y = leg[sel];

  // R2: a neighbour-fed leg reflects the neighbour, not the group input
  p_nbr_leg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    leg_src[sel] |-> (y == nbr_in[sel]));

  // R1: a group-fed leg reflects its group input
  p_grp_leg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !leg_src[sel] |-> (y == grp_in[sel]));

endmodule

// File: rtl/xpt_path_stage.sv
module xpt_path_stage
  import xpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  path_mode_e mode,
  input  logic       d,
  input  logic       stb_lvl,
  input  logic       stb_rise,
  input  logic       ce_lvl,
  output logic       q
);

  logic stor_q, stor_d;
  logic cap;

  assign cap = stb_rise && ce_lvl;

  always_comb begin
    stor_d = stor_q;
    unique case (mode)
      PM_LATCH: if (stb_lvl) stor_d = d;
      PM_REG:   if (cap)     stor_d = d;
      default:  stor_d = stor_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stor_q <= 1'b0;
    else        stor_q <= stor_d;
  end

  always_comb begin
    unique case (mode)
      PM_LATCH: q = stb_lvl ? d : stor_q;
      PM_REG:   q = stor_q;
      default:  q = d;
    endcase
  end

  // R4: register holds when no enabled rising strobe is seen
  p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_REG && !cap) |=> $stable(stor_q));

  // R4: an enabled rising strobe captures the data present at that edge
  p_reg_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_REG && cap) |=> (stor_q == $past(d)));

  // R5: a closed latch keeps its content
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_LATCH && !stb_lvl) |=> $stable(stor_q));

endmodule

// File: rtl/xpt_io_cell.sv
module xpt_io_cell
  import xpt_pkg::*;
#(
  parameter int            AW      = 4,
  parameter logic [AW-1:0] CELL_ID = 4'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NLEG-1:0]  grp_in,
  input  logic [NLEG-1:0]  nbr_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             pad_in,
  input  logic             oe_in,
  input  logic [1:0]       gstb,
  input  logic [1:0]       gce,
  input  logic             io_stb,
  input  logic             io_ce,
  output logic             grp_out,
  output logic             mux_out,
  output logic             pad_do,
  output logic             pad_oe
);

  // asynchronous assertion, synchronous release (R12)
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  cell_cfg_t cfg;
  logic      cfg_valid;
  logic      stb_lvl, stb_rise, ce_lvl;
  logic      out_q;
  logic      drive_req, data_sel;

  xpt_cfg_reg #(.AW(AW), .CELL_ID(CELL_ID)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .cfg       (cfg),
    .cfg_valid (cfg_valid)
  );

  xpt_clk_sel clk_sel_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clk_sel  (cfg.clk_sel),
    .ce_sel   (cfg.ce_sel),
    .gstb     (gstb),
    .gce      (gce),
    .io_stb   (io_stb),
    .io_ce    (io_ce),
    .stb_lvl  (stb_lvl),
    .stb_rise (stb_rise),
    .ce_lvl   (ce_lvl)
  );

  xpt_leg_mux leg_mux_i (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .leg_src (cfg.leg_src),
    .grp_in  (grp_in),
    .nbr_in  (nbr_in),
    .sel     (sel),
    .y       (mux_out)
  );

  xpt_path_stage in_stage_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .mode     (cfg.in_mode),
    .d        (pad_in),
    .stb_lvl  (stb_lvl),
    .stb_rise (stb_rise),
    .ce_lvl   (ce_lvl),
    .q        (grp_out)
  );

  xpt_path_stage out_stage_i (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .mode     (cfg.out_mode),
    .d        (mux_out),
    .stb_lvl  (stb_lvl),
    .stb_rise (stb_rise),
    .ce_lvl   (ce_lvl),
    .q        (out_q)
  );

  always_comb begin
    drive_req = cfg.oe_pol ? oe_in : !oe_in;
    data_sel  = cfg.force_en ? cfg.force_val : out_q;
    if (!cfg_valid) begin
      pad_oe = 1'b0;
      pad_do = 1'b0;
    end else if (cfg.odrain) begin
      pad_oe = drive_req && !data_sel;
      pad_do = 1'b0;
    end else begin
      pad_oe = drive_req;
      pad_do = data_sel;
    end
  end

  // R9: no drive before configuration
  p_hiz_unconfigured_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    !cfg_valid |-> (!pad_oe && !pad_do));

  // R8: open drain only ever drives low
  p_odrain_low_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cfg_valid && cfg.odrain) |-> !pad_do);

  // R7: forced level wins over the selector
  p_force_level_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cfg_valid && cfg.force_en && !cfg.odrain) |-> (pad_do == cfg.force_val));

  // R6: enable follows oe_in at the programmed polarity
  p_oe_polarity_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cfg_valid && !cfg.odrain) |-> (pad_oe == (oe_in == cfg.oe_pol)));

endmodule

// File: tb/xpt_io_cell_tb_top.sv
module xpt_io_cell_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MY_ID = 4'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [3:0]  grp_in, nbr_in;
  logic [1:0]  sel;
  logic        pad_in, oe_in;
  logic [1:0]  gstb, gce;
  logic        io_stb, io_ce;
  logic        grp_out, mux_out, pad_do, pad_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_io_cell #(.AW(4), .CELL_ID(MY_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .grp_in(grp_in), .nbr_in(nbr_in), .sel(sel),
    .pad_in(pad_in), .oe_in(oe_in), .gstb(gstb), .gce(gce),
    .io_stb(io_stb), .io_ce(io_ce), .grp_out(grp_out), .mux_out(mux_out),
    .pad_do(pad_do), .pad_oe(pad_oe)
  );

  // expected item: bit3 pad_oe, bit2 pad_do, bit1 grp_out, bit0 mux_out
  typedef struct packed {
    logic [3:0] mask;
    logic [3:0] val;
    logic [7:0] req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [3:0] act;
      e   = exp_q.pop_front();
      act = {pad_oe, pad_do, grp_out, mux_out};
      n_cmp++;
      if ((act & e.mask) !== (e.val & e.mask)) begin
        n_bad++;
        $display("FAIL R%0d: actual oe/do/gout/mout=%b expected=%b mask=%b",
                 e.req, act, e.val, e.mask);
      end
    end
  end

  function automatic logic [15:0] mk(input logic [3:0] leg, input logic [1:0] inm,
      input logic [1:0] outm, input logic pol, input logic fe, input logic fv,
      input logic od, input logic [1:0] cs, input logic [1:0] ces);
    return {ces, cs, od, fv, fe, pol, outm, inm, leg};
  endfunction

  task automatic expect_next(input logic [3:0] m, input logic [3:0] v, input int r);
    exp_t e;
    e.mask = m; e.val = v; e.req = 8'(r);
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wcfg(input logic [3:0] a, input logic [15:0] w);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    grp_in = 0; nbr_in = 0; sel = 0; pad_in = 0; oe_in = 1'b1;
    gstb = 0; gce = 0; io_stb = 0; io_ce = 0;
    idle(2);
    expect_next(4'b1100, 4'b0000, 12);           // R12: in reset, no drive
    rst_n = 1'b1;
    idle(3);
    expect_next(4'b1100, 4'b0000, 9);            // R9: unconfigured, oe_in high

    // combinational cell, group legs
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd0, 1, 0, 0, 0, 2'd0, 2'd3));
    grp_in = 4'b0100; sel = 2'd2;
    expect_next(4'b1101, 4'b1101, 1);            // R1
    sel = 2'd1;
    expect_next(4'b0101, 4'b0000, 1);            // R1
    grp_in = 4'b1000; sel = 2'd3;
    expect_next(4'b0101, 4'b0101, 1);            // R1
    grp_in = 4'b1110; sel = 2'd0; pad_in = 1'b1;
    expect_next(4'b0111, 4'b0010, 3);            // R3: input comb, mux 0
    pad_in = 1'b0;
    expect_next(4'b0010, 4'b0000, 3);            // R3

    // neighbour legs 0 and 2
    wcfg(MY_ID, mk(4'b0101, 2'd0, 2'd0, 1, 0, 0, 0, 2'd0, 2'd3));
    grp_in = 4'b1111; nbr_in = 4'b0000;
    sel = 2'd0; expect_next(4'b0001, 4'b0000, 2); // R2
    sel = 2'd1; expect_next(4'b0001, 4'b0001, 2); // R2
    sel = 2'd2; expect_next(4'b0101, 4'b0000, 2); // R2
    nbr_in = 4'b0001; sel = 2'd0;
    expect_next(4'b0101, 4'b0101, 2);             // R2

    // polarity
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd0, 0, 0, 0, 0, 2'd0, 2'd3));
    oe_in = 1'b0; expect_next(4'b1000, 4'b1000, 6); // R6
    oe_in = 1'b1; expect_next(4'b1000, 4'b0000, 6); // R6

    // forced level
    grp_in = 4'b0000; sel = 2'd0;
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd0, 1, 1, 1, 0, 2'd0, 2'd3));
    expect_next(4'b0101, 4'b0100, 7);             // R7: forced 1 over mux 0
    grp_in = 4'b0001;
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd0, 1, 1, 0, 0, 2'd0, 2'd3));
    expect_next(4'b0101, 4'b0001, 7);             // R7: forced 0 over mux 1

    // open drain
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd0, 1, 0, 0, 1, 2'd0, 2'd3));
    expect_next(4'b1100, 4'b0000, 8);             // R8: data 1 released
    grp_in = 4'b0000;
    expect_next(4'b1100, 4'b1000, 8);             // R8: data 0 driven low
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd0, 1, 1, 1, 1, 2'd0, 2'd3));
    expect_next(4'b1100, 4'b0000, 8);             // R8 with R7: forced 1 released

    // output register on gstb[0], enable always
    grp_in = 4'b0001;
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd2, 1, 0, 0, 0, 2'd0, 2'd3));
    expect_next(4'b0100, 4'b0000, 4);             // R4: no strobe yet
    gstb[0] = 1'b1;
    expect_next(4'b0100, 4'b0100, 4);             // R4: captured on rise
    grp_in = 4'b0000;
    expect_next(4'b0100, 4'b0100, 4);             // R4: strobe held high
    gstb[0] = 1'b0;
    expect_next(4'b0100, 4'b0100, 4);             // R4
    gstb[1] = 1'b1;
    expect_next(4'b0100, 4'b0100, 11);            // R11: unselected strobe
    gstb[1] = 1'b0;
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd2, 1, 0, 0, 0, 2'd0, 2'd0));
    gce[0] = 1'b0; gstb[0] = 1'b1;
    expect_next(4'b0100, 4'b0100, 4);             // R4: rise without enable
    gstb[0] = 1'b0;
    expect_next(4'b0100, 4'b0100, 11);            // R11
    gce[0] = 1'b1; gstb[0] = 1'b1;
    expect_next(4'b0100, 4'b0000, 4);             // R4: rise with enable
    gstb[0] = 1'b0; gce[0] = 1'b0;

    // input latch on io_stb
    wcfg(MY_ID, mk(4'b0000, 2'd1, 2'd0, 1, 0, 0, 0, 2'd2, 2'd3));
    io_stb = 1'b1; pad_in = 1'b1;
    expect_next(4'b0010, 4'b0010, 5);             // R5: transparent
    io_stb = 1'b0;
    expect_next(4'b0010, 4'b0010, 5);             // R5
    pad_in = 1'b0;
    expect_next(4'b0010, 4'b0010, 5);             // R5: holding
    gstb = 2'b11;
    expect_next(4'b0010, 4'b0010, 11);            // R11: globals ignored
    gstb = 2'b00;

    // foreign-address write
    grp_in = 4'b0000;
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd0, 1, 0, 0, 0, 2'd0, 2'd3));
    wcfg(MY_ID + 4'd1, mk(4'b0000, 2'd0, 2'd0, 1, 1, 1, 0, 2'd0, 2'd3));
    expect_next(4'b1100, 4'b1000, 10);            // R10

    // reset clears storage and configuration
    grp_in = 4'b0001;
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd2, 1, 0, 0, 0, 2'd0, 2'd3));
    gstb[0] = 1'b1;
    expect_next(4'b0100, 4'b0100, 4);             // R4: register now 1
    gstb[0] = 1'b0;
    rst_n = 1'b0;
    expect_next(4'b1100, 4'b0000, 12);            // R12
    rst_n = 1'b1;
    idle(3);
    expect_next(4'b1100, 4'b0000, 9);             // R9: configuration cleared
    wcfg(MY_ID, mk(4'b0000, 2'd0, 2'd2, 1, 0, 0, 0, 2'd0, 2'd3));
    expect_next(4'b1100, 4'b1000, 12);            // R12: register cleared

    idle(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule